// File: doc/BRIEF.md
# Front-Panel Control Sequencer

This block sits on the console side of a small processor. It turns operator switch actions into the low-level handshakes that halt, step, resume and service the processor. It watches the processor's instruction-fetch strobe so that each service request reaches the processor at a point where the processor can honour it on the next fetch. It produces the start pulse for every resume and sets its width so that a pending request is already in place before the processor wakes up.

The debounced switches and the processor strobes each pass through a two-stage synchroniser before any edge is detected. A service request is raised on the trailing edge of a fetch. It is dropped once a fetch that reads the control word from the console has finished, and the stopped flag is set at that moment. The block keeps the control-word code that the console's bus drivers must present. This code is the Stop word in every state, except after a register-select action that was accepted while the processor was stopped.

Top module: `panel_sequencer`

## Requirements
- R1: After reset, `serv_n` and `start_n` are high, `stopped` is 1 and `ccw_code` is 16'h1C00 (the Stop word).
- R2: In run mode, with `sw_stop` held, `serv_n` goes low on the first synchronised rising edge of `if_n` after the stop level has been seen. It does not go low before that edge.
- R3: While a service request is pending, `serv_n` returns high and `stopped` becomes 1 at the trailing edge of an `if_n` low period in which `in_n` was low and `dev0_fc0` was high. A fetch without those qualifiers leaves `serv_n` low.
- R4: Every `start_n` low pulse lasts exactly LEAD_CYC clock cycles, with LEAD_CYC = ceil(1.6 * CLK_MHZ). `stopped` clears on the clock edge that releases `start_n`.
- R5: An accepted register-select action drives `serv_n` and `start_n` low on the same clock edge. `serv_n` stays low after `start_n` is released.
- R6: An accepted select sets `ccw_code` to 16'h1C00 | (sel_target << 1) | sel_write. `sel_target` is one-hot: bit 0 is memory, bit 1 is A, bit 2 is X, bit 3 is I and bit 4 is P. `sel_write`=1 moves data into the processor. The code returns to 16'h1C00 when the control-word fetch completes.
- R7: A rising edge of `sw_sel` is ignored when the block is not stopped, or when `sel_target` is not exactly one-hot. In that case `serv_n`, `start_n` and `ccw_code` do not change.
- R8: A rising edge of `sw_run` while stopped with `sw_stop` held gives a start pulse with `serv_n` high. `serv_n` then goes low on the first `if_n` trailing edge after the release, so that exactly one memory instruction runs.
- R9: A rising edge of `sw_run` while stopped with `sw_stop` released gives a start pulse with `serv_n` high. `serv_n` then stays high through later fetches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, CLK_MHZ MHz |
| rst | input | 1 | Synchronous reset, active high |
| sw_stop | input | 1 | Debounced STOP switch level, 1 = active |
| sw_run | input | 1 | Debounced RUN switch, 1 = pressed |
| sw_sel | input | 1 | Debounced register-select action, 1 = pressed |
| sel_target | input | 5 | One-hot transfer target (memory, A, X, I, P) |
| sel_write | input | 1 | 1 = transfer into the processor |
| if_n | input | 1 | Instruction-fetch strobe, active low |
| in_n | input | 1 | Input strobe, active low |
| dev0_fc0 | input | 1 | 1 while the bus addresses device 0, function 0 |
| serv_n | output | 1 | Console service request, active low |
| start_n | output | 1 | Processor start pulse, active low |
| ccw_code | output | 16 | Control word to present on a control-word fetch |
| stopped | output | 1 | 1 while the processor is halted |

## Verification
The bench presses STOP well before a fetch and then checks two things. The request must wait for a trailing fetch edge, and a plain memory fetch must not release it. A design that keyed on the leading edge, or that released on any fetch, would lose or cut short the halt. Register selects are pressed during run and with two target bits set. A design that accepted them would change the control word while a program is running. The start pulse is measured to the cycle, and the single step is checked so that the request appears only after one memory fetch, not during the start pulse.

// File: rtl/panel_pkg.sv
package panel_pkg;

    localparam logic [15:0] CCW_STOP = 16'h1C00;

    typedef enum logic [2:0] {
        PS_STOPPED,
        PS_START,
        PS_RUN,
        PS_ARM,
        PS_STEPW,
        PS_SERV
    } pstate_e;

    typedef enum logic [1:0] {
        SK_RUN,
        SK_STEP,
        SK_REG
    } start_kind_e;

    // synchronised view of the panel and processor strobes
    typedef struct packed {
        logic stop_lvl;
        logic run_rise;
        logic sel_rise;
        logic if_trail;
        logic fetch_qual;
    } panel_ev_t;

    function automatic int unsigned lead_cycles(int unsigned mhz);
        return (16 * mhz + 9) / 10;
    endfunction

    function automatic logic is_onehot5(logic [4:0] t);
        return (t != 5'd0) && ((t & (t - 5'd1)) == 5'd0);
    endfunction

    function automatic logic [15:0] ccw_encode(logic [4:0] tgt, logic wr);
        return CCW_STOP | {10'd0, tgt, wr};
    endfunction

endpackage

// File: rtl/panel_sync.sv
module panel_sync #(
    parameter int W = 6,
    parameter logic [W-1:0] IDLE = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] raw,
    output logic [W-1:0] lvl,
    output logic [W-1:0] lvl_d
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic s1, s2, s3;
        always_ff @(posedge clk) begin
            if (rst) begin
                s1 <= IDLE[i];
                s2 <= IDLE[i];
                s3 <= IDLE[i];
            end else begin
                s1 <= raw[i];
                s2 <= s1;
                s3 <= s2;
            end
        end
        assign lvl[i]   = s2;
        assign lvl_d[i] = s3;
    end
endmodule

// File: rtl/lead_timer.sv
module lead_timer #(
    parameter int unsigned CYC = 160
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic done
);
    localparam int CW = (CYC > 1) ? $clog2(CYC + 1) : 1;
    localparam logic [CW-1:0] LOADV = CW'(CYC - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= LOADV;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);

    p_count_bounded_r4: assert property (@(posedge clk) disable iff (rst)
        cnt <= LOADV);
    p_load_value_r4: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt == LOADV));
endmodule

// File: rtl/panel_fsm.sv
module panel_fsm
    import panel_pkg::*;
#(
    parameter int unsigned LEAD = 160
) (
    input  logic        clk,
    input  logic        rst,
    input  panel_ev_t   ev,
    input  logic [4:0]  sel_target,
    input  logic        sel_write,
    input  logic        t_done,
    output logic        t_load,
    output logic        serv_n,
    output logic        start_n,
    output logic        stopped,
    output logic [15:0] ccw_code
);
    pstate_e     state;
    start_kind_e kind;
    logic        got_fetch;
    logic        sel_ok;

    always_comb begin
        sel_ok = ev.sel_rise && is_onehot5(sel_target);
        t_load = (state == PS_STOPPED) && (sel_ok || ev.run_rise);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= PS_STOPPED;
            kind      <= SK_RUN;
            got_fetch <= 1'b0;
            serv_n    <= 1'b1;
            start_n   <= 1'b1;
            stopped   <= 1'b1;
            ccw_code  <= CCW_STOP;
        end else begin
            unique case (state)
                PS_STOPPED: begin
                    if (sel_ok) begin
                        ccw_code <= ccw_encode(sel_target, sel_write);
                        serv_n   <= 1'b0;
                        start_n  <= 1'b0;
                        kind     <= SK_REG;
                        state    <= PS_START;
                    end else if (ev.run_rise) begin
                        start_n  <= 1'b0;
                        kind     <= ev.stop_lvl ? SK_STEP : SK_RUN;
                        state    <= PS_START;
                    end
                end
                PS_START: begin
                    if (t_done) begin
                        start_n <= 1'b1;
                        stopped <= 1'b0;
                        unique case (kind)
                            SK_REG:  state <= PS_SERV;
                            SK_STEP: state <= PS_STEPW;
                            default: state <= PS_RUN;
                        endcase
                        got_fetch <= 1'b0;
                    end
                end
                PS_RUN: begin
                    if (ev.stop_lvl)
                        state <= PS_ARM;
                end
                PS_ARM, PS_STEPW: begin
                    if (ev.if_trail) begin
                        serv_n    <= 1'b0;
                        got_fetch <= 1'b0;
                        state     <= PS_SERV;
                    end
                end
                PS_SERV: begin
                    if (ev.if_trail) begin
                        got_fetch <= 1'b0;
                        if (got_fetch) begin
                            serv_n   <= 1'b1;
                            stopped  <= 1'b1;
                            ccw_code <= CCW_STOP;
                            state    <= PS_STOPPED;
                        end
                    end else if (ev.fetch_qual) begin
                        got_fetch <= 1'b1;
                    end
                end
                default: state <= PS_STOPPED;
            endcase
        end
    end

    // width of the current start pulse, kept for checking only
    logic [$clog2(LEAD + 2)-1:0] low_cnt;
    always_ff @(posedge clk) begin
        if (rst || start_n)
            low_cnt <= '0;
        else if (low_cnt != '1)
            low_cnt <= low_cnt + 1'b1;
    end

    p_start_width_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(start_n) |-> (low_cnt == ($bits(low_cnt))'(LEAD)));
    p_release_sets_stopped_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(serv_n) |-> stopped);
    p_reg_same_edge_r5: assert property (@(posedge clk) disable iff (rst)
        ($fell(start_n) && !serv_n) |-> $past(serv_n));
    p_step_no_serv_r8: assert property (@(posedge clk) disable iff (rst)
        (!start_n && kind == SK_STEP) |-> serv_n);
    p_run_no_serv_r9: assert property (@(posedge clk) disable iff (rst)
        (!start_n && kind == SK_RUN) |-> serv_n);
    p_ccw_onehot_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ccw_code[5:1]));
    p_ccw_stop_when_running_r7: assert property (@(posedge clk) disable iff (rst)
        (state == PS_RUN) |-> (ccw_code == CCW_STOP));
    p_stop_request_r2: assert property (@(posedge clk) disable iff (rst)
        ($fell(serv_n) && start_n) |-> $past(ev.if_trail));
endmodule

// File: rtl/panel_sequencer.sv
module panel_sequencer
    import panel_pkg::*;
#(
    parameter int unsigned CLK_MHZ = 100
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        sw_stop,
    input  logic        sw_run,
    input  logic        sw_sel,
    input  logic [4:0]  sel_target,
    input  logic        sel_write,
    input  logic        if_n,
    input  logic        in_n,
    input  logic        dev0_fc0,
    output logic        serv_n,
    output logic        start_n,
    output logic [15:0] ccw_code,
    output logic        stopped
);
    localparam int unsigned LEAD_CYC = lead_cycles(CLK_MHZ);
    localparam int NIN = 6;
    // bit order: if_n, in_n, dev0_fc0, stop, run, sel
    localparam logic [NIN-1:0] IDLE = 6'b110000;

    logic [NIN-1:0] raw, lvl, lvl_d;
    panel_ev_t      ev;
    logic           t_load, t_done;

    assign raw = {if_n, in_n, dev0_fc0, sw_stop, sw_run, sw_sel};

    panel_sync #(.W(NIN), .IDLE(IDLE)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .raw  (raw),
        .lvl  (lvl),
        .lvl_d(lvl_d)
    );

    always_comb begin
        ev.stop_lvl   = lvl[2];
        ev.run_rise   = lvl[1] & ~lvl_d[1];
        ev.sel_rise   = lvl[0] & ~lvl_d[0];
        ev.if_trail   = lvl[5] & ~lvl_d[5];
        ev.fetch_qual = ~lvl[5] & ~lvl[4] & lvl[3];
    end

    lead_timer #(.CYC(LEAD_CYC)) u_timer (
        .clk (clk),
        .rst (rst),
        .load(t_load),
        .done(t_done)
    );

    panel_fsm #(.LEAD(LEAD_CYC)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .sel_target(sel_target),
        .sel_write (sel_write),
        .t_done    (t_done),
        .t_load    (t_load),
        .serv_n    (serv_n),
        .start_n   (start_n),
        .stopped   (stopped),
        .ccw_code  (ccw_code)
    );
endmodule

// File: tb/tb_panel_sequencer.sv
`timescale 1ns/1ps
module tb_panel_sequencer;
    localparam int CLK_MHZ = 100;
    localparam int LEAD = (16 * CLK_MHZ + 9) / 10;

    logic clk = 0, rst = 1;
    logic sw_stop = 0, sw_run = 0, sw_sel = 0, sel_write = 0;
    logic [4:0] sel_target = 0;
    logic if_n = 1, in_n = 1, dev0_fc0 = 0;
    logic serv_n, start_n, stopped;
    logic [15:0] ccw_code;

    int checks = 0, errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    panel_sequencer #(.CLK_MHZ(CLK_MHZ)) dut (
        .clk(clk), .rst(rst), .sw_stop(sw_stop), .sw_run(sw_run), .sw_sel(sw_sel),
        .sel_target(sel_target), .sel_write(sel_write), .if_n(if_n), .in_n(in_n),
        .dev0_fc0(dev0_fc0), .serv_n(serv_n), .start_n(start_n),
        .ccw_code(ccw_code), .stopped(stopped)
    );

    // behavioural reference: modes as integers, inputs seen two samples late
    int   md, kd, left;
    bit   m_serv, m_start, m_stopped, m_got;
    logic [15:0] m_ccw;
    logic [5:0] p1, p2, p3, rv;
    localparam logic [5:0] IDL = 6'b110000;

    function automatic bit one_hot(logic [4:0] t);
        int n = 0;
        for (int i = 0; i < 5; i++) if (t[i]) n++;
        return n == 1;
    endfunction

    always @(posedge clk) begin
        rv = {if_n, in_n, dev0_fc0, sw_stop, sw_run, sw_sel};
        if (rst) begin
            md = 0; kd = 0; left = 0; m_got = 0;
            m_serv = 1; m_start = 1; m_stopped = 1; m_ccw = 16'h1C00;
            p1 = IDL; p2 = IDL; p3 = IDL;
        end else begin
            bit stop_l, run_r, sel_r, if_tr, fq;
            stop_l = p2[2];
            run_r  = p2[1] && !p3[1];
            sel_r  = p2[0] && !p3[0];
            if_tr  = p2[5] && !p3[5];
            fq     = !p2[5] && !p2[4] && p2[3];
            case (md)
                0: if (sel_r && one_hot(sel_target)) begin
                       m_ccw = 16'h1C00 + 16'(sel_target) * 2 + 16'(sel_write);
                       m_serv = 0; m_start = 0; kd = 2; md = 1; left = LEAD;
                   end else if (run_r) begin
                       m_start = 0; kd = stop_l ? 1 : 0; md = 1; left = LEAD;
                   end
                1: if (left == 1) begin
                       m_start = 1; m_stopped = 0; m_got = 0;
                       md = (kd == 2) ? 5 : (kd == 1) ? 4 : 2;
                   end else left--;
                2: if (stop_l) md = 3;
                3, 4: if (if_tr) begin m_serv = 0; m_got = 0; md = 5; end
                5: if (if_tr) begin
                       if (m_got) begin
                           m_serv = 1; m_stopped = 1; m_ccw = 16'h1C00; md = 0;
                       end
                       m_got = 0;
                   end else if (fq) m_got = 1;
                default: md = 0;
            endcase
            p3 = p2; p2 = p1; p1 = rv;
        end
    end

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) if (!rst && !finished) begin
        check("R2/R3 serv_n vs model", {15'd0, serv_n}, {15'd0, m_serv});
        check("R4 start_n vs model", {15'd0, start_n}, {15'd0, m_start});
        check("R3 stopped vs model", {15'd0, stopped}, {15'd0, m_stopped});
        check("R6 ccw_code vs model", ccw_code, m_ccw);
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic press_run();
        sw_run = 1; cyc(4); sw_run = 0; cyc(2);
    endtask

    task automatic press_sel(logic [4:0] t, logic w);
        sel_target = t; sel_write = w; cyc(1);
        sw_sel = 1; cyc(4); sw_sel = 0; cyc(2);
    endtask

    task automatic fetch(bit console);
        if_n = 0;
        if (console) begin in_n = 0; dev0_fc0 = 1; end
        cyc(6);
        if_n = 1; in_n = 1; dev0_fc0 = 0;
        cyc(6);
    endtask

    // waits for the next start pulse and returns its width in cycles
    task automatic measure_start(output int w, output bit serv_at_fall);
        int g = 0;
        w = 0; serv_at_fall = 1;
        while (start_n && g < 50) begin @(negedge clk); g++; end
        serv_at_fall = serv_n;
        while (!start_n && w < 10000) begin @(negedge clk); w++; end
    endtask

    initial begin
        int w;
        bit sf;
        cyc(3); rst = 0; cyc(1);
        check("R1 serv_n reset", {15'd0, serv_n}, 16'd1);
        check("R1 start_n reset", {15'd0, start_n}, 16'd1);
        check("R1 stopped reset", {15'd0, stopped}, 16'd1);
        check("R1 ccw reset", ccw_code, 16'h1C00);

        // R9: run from stopped with STOP released
        sw_run = 1;
        measure_start(w, sf);
        sw_run = 0;
        check("R4 start width (run)", 16'(w), 16'(LEAD));
        check("R9 no serv during run start", {15'd0, sf}, 16'd1);
        check("R9 stopped cleared", {15'd0, stopped}, 16'd0);
        fetch(0); fetch(0);
        check("R9 serv stays high in run", {15'd0, serv_n}, 16'd1);

        // R7: register select during run is ignored
        press_sel(5'b00010, 1'b1); cyc(6);
        check("R7 select in run serv_n", {15'd0, serv_n}, 16'd1);
        check("R7 select in run start_n", {15'd0, start_n}, 16'd1);
        check("R7 select in run ccw", ccw_code, 16'h1C00);

        // R2/R3: stop request timed to fetch trailing edge
        sw_stop = 1; cyc(8);
        check("R2 no serv before fetch edge", {15'd0, serv_n}, 16'd1);
        fetch(0);
        check("R2 serv after fetch edge", {15'd0, serv_n}, 16'd0);
        fetch(0);
        check("R3 memory fetch keeps serv", {15'd0, serv_n}, 16'd0);
        check("R3 not yet stopped", {15'd0, stopped}, 16'd0);
        fetch(1);
        check("R3 serv released", {15'd0, serv_n}, 16'd1);
        check("R3 stopped set", {15'd0, stopped}, 16'd1);

        // R5/R6: register select into A while stopped
        sel_target = 5'b00010; sel_write = 1; cyc(1);
        sw_sel = 1;
        measure_start(w, sf);
        sw_sel = 0;
        check("R5 serv low with start", {15'd0, sf}, 16'd0);
        check("R4 start width (select)", 16'(w), 16'(LEAD));
        check("R5 serv held after start", {15'd0, serv_n}, 16'd0);
        check("R6 ccw write A", ccw_code, 16'h1C05);
        fetch(1);
        check("R6 ccw back to stop", ccw_code, 16'h1C00);
        check("R3 stopped after select", {15'd0, stopped}, 16'd1);

        // R7: two target bits set is ignored
        press_sel(5'b00011, 1'b0); cyc(6);
        check("R7 multi-bit serv_n", {15'd0, serv_n}, 16'd1);
        check("R7 multi-bit start_n", {15'd0, start_n}, 16'd1);
        check("R7 multi-bit ccw", ccw_code, 16'h1C00);

        // R8: single step, STOP still held
        sw_run = 1;
        measure_start(w, sf);
        sw_run = 0;
        check("R8 no serv at step start", {15'd0, sf}, 16'd1);
        check("R4 start width (step)", 16'(w), 16'(LEAD));
        cyc(4);
        check("R8 serv high before fetch", {15'd0, serv_n}, 16'd1);
        fetch(0);
        check("R8 serv after one fetch", {15'd0, serv_n}, 16'd0);
        fetch(1);
        check("R8 stopped after step", {15'd0, stopped}, 16'd1);

        // R6: read P
        press_sel(5'b10000, 1'b0); cyc(2);
        check("R6 ccw read P", ccw_code, 16'h1C20);
        while (!start_n) cyc(1);
        fetch(1);
        check("R6 ccw after P", ccw_code, 16'h1C00);

        // R9: back to run
        sw_stop = 0; cyc(4);
        press_run();
        while (!start_n) cyc(1);
        fetch(0);
        check("R9 running again", {15'd0, stopped}, 16'd0);
        check("R9 serv high", {15'd0, serv_n}, 16'd1);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule